// File: doc/BRIEF.md
# SIMT Lane-Enable Mask Controller

This block holds the lane-enable mask of a scalar sequencer that drives a group of vector lanes, one mask bit per lane. It carries out structured divergent control flow without a reconvergence stack. Each construct is a short sequence of save-and-modify mask commands built from AND, XOR, OR and AND-NOT. The operands are the live mask, a per-lane condition word, a small bank of save registers and a loop-break accumulator.

The sequencer decodes a mask command and presents it together with its operands. Every command completes on the next rising clock edge. A combinational all-lanes-off flag lets the sequencer skip a region nobody executes. A registered loop flag reports whether a loop back-edge leaves any lane alive. Debug visibility of one save entry and of the accumulator is provided so the bank can be inspected.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset the mask is all ones, the accumulator and every save entry are zero, `execZero` is low and `loopTaken` is low.
- R2: Command code 1 (if) sets the mask to old mask AND `condWord` and writes save entry `dstIdx` with the lanes it turned off (old mask AND NOT `condWord`).
- R3: Command code 2 (else) writes the old mask into save entry `dstIdx` and sets the mask to (old mask OR save entry `srcIdx`) XOR old mask.
- R4: Command code 3 (end of conditional) sets the mask to mask OR save entry `srcIdx`.
- R5: Command code 4 (break) sets the accumulator to accumulator OR mask and leaves the mask unchanged.
- R6: Command code 5 (conditional break) ORs `condWord` into the accumulator; command code 6 (else-break) ORs save entry `srcIdx` into it.
- R7: Command code 7 (loop back-edge) sets the mask to mask AND NOT accumulator; `loopTaken` is high in the cycle after that edge exactly when the new mask is nonzero, and low after every other command.
- R8: Command code 8 (constant kill) clears the whole mask when `killImm` bit 31 is set and leaves it unchanged when bit 31 is clear.
- R9: Command code 9 (per-lane kill) clears every mask bit whose `laneNeg` bit is set (the lane's value is negative) and keeps the others.
- R10: `execZero` is high in exactly the cycles in which the mask register holds zero.
- R11: With `cmdValid` low, or with command code 0, the mask, accumulator and save entries keep their values.
- R12: `saveView` shows save entry `viewIdx` combinationally and `accView` shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Mask command code |
| dstIdx | input | 2 | Save entry written by if/else |
| srcIdx | input | 2 | Save entry read by else, end, else-break |
| condWord | input | 64 | Per-lane condition word |
| killImm | input | 32 | Constant kill operand |
| laneNeg | input | 64 | Per-lane negative-value flags for lane kill |
| viewIdx | input | 2 | Save entry shown on saveView |
| execMask | output | 64 | Current lane-enable mask |
| execZero | output | 1 | Mask is all zero |
| loopTaken | output | 1 | Last loop back-edge left live lanes |
| accView | output | 64 | Loop-break accumulator |
| saveView | output | 64 | Selected save entry |

## Verification
The hardest situation to reach is a loop back-edge that kills every lane while the enclosing conditional still owes lanes back. Only that order makes `loopTaken` low, `execZero` high and the next end-of-conditional restore lanes out of a zero mask. The stimulus table first narrows the mask with an if. It then breaks with the whole live set and takes the back-edge. The end-of-conditional must then revive exactly the parked lanes. A second back-edge, after a conditional break, leaves lanes alive so that the taken case is covered too.

// File: rtl/emask_pkg.sv
package emask_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_IF      = 4'd1,
    OP_ELSE    = 4'd2,
    OP_END     = 4'd3,
    OP_BRK     = 4'd4,
    OP_IFBRK   = 4'd5,
    OP_ELSEBRK = 4'd6,
    OP_LOOP    = 4'd7,
    OP_KILLK   = 4'd8,
    OP_KILLV   = 4'd9
  } maskOp_e;

  typedef enum logic [2:0] {
    MS_HOLD,
    MS_AND_COND,
    MS_FLIP_REOPEN,
    MS_OR_SAVE,
    MS_ANDN_ACC,
    MS_CLEAR,
    MS_ANDN_NEG
  } maskSel_e;

  typedef enum logic [1:0] {
    AS_HOLD,
    AS_OR_MASK,
    AS_OR_COND,
    AS_OR_SAVE
  } accSel_e;

  typedef enum logic [1:0] {
    SS_HOLD,
    SS_TURNED_OFF,
    SS_OLD_MASK
  } saveSel_e;

  typedef struct packed {
    maskSel_e maskSel;
    accSel_e  accSel;
    saveSel_e saveSel;
    logic     loopChk;
  } strobe_t;

endpackage

// File: rtl/emask_ctrl.sv
module emask_ctrl
  import emask_pkg::*;
(
  input  logic       cmdValid,
  input  logic [3:0] cmdOp,
  input  logic       killSign,
  output strobe_t    strobe
);

  always_comb begin
    strobe = '{maskSel: MS_HOLD, accSel: AS_HOLD, saveSel: SS_HOLD, loopChk: 1'b0};
    if (cmdValid) begin
      unique case (cmdOp)
        OP_IF: begin
          strobe.maskSel = MS_AND_COND;
          strobe.saveSel = SS_TURNED_OFF;
        end
        OP_ELSE: begin
          strobe.maskSel = MS_FLIP_REOPEN;
          strobe.saveSel = SS_OLD_MASK;
        end
        OP_END:     strobe.maskSel = MS_OR_SAVE;
        OP_BRK:     strobe.accSel  = AS_OR_MASK;
        OP_IFBRK:   strobe.accSel  = AS_OR_COND;
        OP_ELSEBRK: strobe.accSel  = AS_OR_SAVE;
        OP_LOOP: begin
          strobe.maskSel = MS_ANDN_ACC;
          strobe.loopChk = 1'b1;
        end
        OP_KILLK:   strobe.maskSel = killSign ? MS_CLEAR : MS_HOLD;
        OP_KILLV:   strobe.maskSel = MS_ANDN_NEG;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!cmdValid)
      assert_idle_hold_R11: assert (strobe.maskSel == MS_HOLD && strobe.accSel == AS_HOLD
                                    && strobe.saveSel == SS_HOLD && !strobe.loopChk);
  end

endmodule

// File: rtl/emask_datapath.sv
module emask_datapath
  import emask_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int SAVE_DEPTH = 4,
  localparam int IDX_W     = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobe,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] viewIdx,
  input  logic [LANES-1:0] condWord,
  input  logic [LANES-1:0] laneNeg,
  output logic [LANES-1:0] maskQ,
  output logic             zeroFlag,
  output logic             loopTakenQ,
  output logic [LANES-1:0] accQ,
  output logic [LANES-1:0] saveView
);

  logic [LANES-1:0] saveQ [SAVE_DEPTH];
  logic [LANES-1:0] srcVal;
  logic [LANES-1:0] maskNext;
  logic [LANES-1:0] accNext;
  logic [LANES-1:0] saveData;

  assign srcVal   = saveQ[srcIdx];
  assign saveView = saveQ[viewIdx];
  assign zeroFlag = ~|maskQ;

  always_comb begin
    unique case (strobe.maskSel)
      MS_AND_COND:    maskNext = maskQ & condWord;
      MS_FLIP_REOPEN: maskNext = (maskQ | srcVal) ^ maskQ;
      MS_OR_SAVE:     maskNext = maskQ | srcVal;
      MS_ANDN_ACC:    maskNext = maskQ & ~accQ;
      MS_CLEAR:       maskNext = '0;
      MS_ANDN_NEG:    maskNext = maskQ & ~laneNeg;
      default:        maskNext = maskQ;
    endcase
  end

  always_comb begin
    unique case (strobe.accSel)
      AS_OR_MASK: accNext = accQ | maskQ;
      AS_OR_COND: accNext = accQ | condWord;
      AS_OR_SAVE: accNext = accQ | srcVal;
      default:    accNext = accQ;
    endcase
  end

  always_comb begin
    unique case (strobe.saveSel)
      SS_TURNED_OFF: saveData = maskQ ^ (maskQ & condWord);
      default:       saveData = maskQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ      <= '1;
      accQ       <= '0;
      loopTakenQ <= 1'b0;
    end else begin
      maskQ      <= maskNext;
      accQ       <= accNext;
      loopTakenQ <= strobe.loopChk && (|maskNext);
    end
  end

  for (genvar e = 0; e < SAVE_DEPTH; e++) begin : g_save
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        saveQ[e] <= '0;
      else if (strobe.saveSel != SS_HOLD && dstIdx == IDX_W'(e))
        saveQ[e] <= saveData;
    end
  end

  assert_if_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.maskSel == MS_AND_COND |=> maskQ == ($past(maskQ) & $past(condWord)));

  assert_loop_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loopTakenQ |-> maskQ != '0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.maskSel == MS_HOLD |=> $stable(maskQ));

  assert_no_new_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.maskSel == MS_ANDN_NEG || strobe.maskSel == MS_ANDN_ACC || strobe.maskSel == MS_CLEAR)
    |=> (maskQ & ~$past(maskQ)) == '0);

  assert_acc_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accSel != AS_HOLD |=> (($past(accQ) & ~accQ) == '0));

endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl
  import emask_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int SAVE_DEPTH = 4,
  localparam int IDX_W     = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOp,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [LANES-1:0] condWord,
  input  logic [31:0]      killImm,
  input  logic [LANES-1:0] laneNeg,
  input  logic [IDX_W-1:0] viewIdx,
  output logic [LANES-1:0] execMask,
  output logic             execZero,
  output logic             loopTaken,
  output logic [LANES-1:0] accView,
  output logic [LANES-1:0] saveView
);

  strobe_t strobe;

  emask_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .killSign (killImm[31]),
    .strobe   (strobe)
  );

  emask_datapath #(.LANES(LANES), .SAVE_DEPTH(SAVE_DEPTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .dstIdx     (dstIdx),
    .srcIdx     (srcIdx),
    .viewIdx    (viewIdx),
    .condWord   (condWord),
    .laneNeg    (laneNeg),
    .maskQ      (execMask),
    .zeroFlag   (execZero),
    .loopTakenQ (loopTaken),
    .accQ       (accView),
    .saveView   (saveView)
  );

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 4'd8 && killImm[31]) |=> execZero);

endmodule

// File: tb/test_exec_mask_ctrl.sv
module test_exec_mask_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [1:0]  dstIdx = '0, srcIdx = '0, viewIdx = '0;
  logic [63:0] condWord = '0, laneNeg = '0;
  logic [31:0] killImm = '0;
  logic [63:0] execMask, accView, saveView;
  logic        execZero, loopTaken;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  exec_mask_ctrl i_exec_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .dstIdx(dstIdx), .srcIdx(srcIdx), .condWord(condWord), .killImm(killImm),
    .laneNeg(laneNeg), .viewIdx(viewIdx), .execMask(execMask), .execZero(execZero),
    .loopTaken(loopTaken), .accView(accView), .saveView(saveView)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  dst;
    logic [1:0]  src;
    logic [63:0] cond;
    logic [31:0] kimm;
    logic [63:0] neg;
    logic [63:0] expMask;
    logic [63:0] expAcc;
    logic        expTaken;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t TBL [NVEC] = '{
    '{4'd1, 2'd0, 2'd0, 64'h00000000FFFFFFFF, 32'h0, 64'h0, 64'h00000000FFFFFFFF, 64'h0, 1'b0}, // R2
    '{4'd2, 2'd1, 2'd0, 64'h0, 32'h0, 64'h0, 64'hFFFFFFFF00000000, 64'h0, 1'b0},                // R3
    '{4'd3, 2'd0, 2'd1, 64'h0, 32'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b0},                // R4
    '{4'd1, 2'd2, 2'd0, 64'h0F0F0F0F0F0F0F0F, 32'h0, 64'h0, 64'h0F0F0F0F0F0F0F0F, 64'h0, 1'b0}, // R2
    '{4'd4, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0F0F0F0F0F0F0F0F, 64'h0F0F0F0F0F0F0F0F, 1'b0}, // R5
    '{4'd7, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0, 64'h0F0F0F0F0F0F0F0F, 1'b0},                // R7 all dead
    '{4'd3, 2'd0, 2'd2, 64'h0, 32'h0, 64'h0, 64'hF0F0F0F0F0F0F0F0, 64'h0F0F0F0F0F0F0F0F, 1'b0}, // R4 from zero
    '{4'd5, 2'd0, 2'd0, 64'h00000000000000F0, 32'h0, 64'h0, 64'hF0F0F0F0F0F0F0F0, 64'h0F0F0F0F0F0F0FFF, 1'b0}, // R6
    '{4'd7, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'hF0F0F0F0F0F0F000, 64'h0F0F0F0F0F0F0FFF, 1'b1}, // R7 taken
    '{4'd9, 2'd0, 2'd0, 64'h0, 32'h0, 64'hFFFF000000000000, 64'h0000F0F0F0F0F000, 64'h0F0F0F0F0F0F0FFF, 1'b0}, // R9
    '{4'd8, 2'd0, 2'd0, 64'h0, 32'h7FFFFFFF, 64'h0, 64'h0000F0F0F0F0F000, 64'h0F0F0F0F0F0F0FFF, 1'b0}, // R8 keep
    '{4'd6, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0000F0F0F0F0F000, 64'hFFFFFFFF0F0F0FFF, 1'b0}, // R6 else-break
    '{4'd0, 2'd3, 2'd0, 64'h0, 32'h80000000, 64'hFFFFFFFFFFFFFFFF, 64'h0000F0F0F0F0F000, 64'hFFFFFFFF0F0F0FFF, 1'b0}, // R11
    '{4'd8, 2'd0, 2'd0, 64'h0, 32'h80000000, 64'h0, 64'h0, 64'hFFFFFFFF0F0F0FFF, 1'b0}          // R8 clear
  };

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic valid, input vec_t v);
    @(negedge clk);
    cmdValid = valid; cmdOp = v.op; dstIdx = v.dst; srcIdx = v.src;
    condWord = v.cond; killImm = v.kimm; laneNeg = v.neg;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t idleVec;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check64("R1 mask", execMask, '1);
    check64("R1 acc", accView, '0);
    check64("R1 zero", {63'b0, execZero}, 64'h0);
    check64("R1 taken", {63'b0, loopTaken}, 64'h0);
    for (int e = 0; e < 4; e++) begin
      viewIdx = 2'(e);
      #1;
      check64("R1 save", saveView, '0);
    end

    for (int i = 0; i < NVEC; i++) begin
      issue(1'b1, TBL[i]);
      check64("R2-table mask", execMask, TBL[i].expMask);
      check64("R5-table acc", accView, TBL[i].expAcc);
      check64("R7 taken", {63'b0, loopTaken}, {63'b0, TBL[i].expTaken});
      check64("R10 zero", {63'b0, execZero}, {63'b0, TBL[i].expMask == 64'h0});
    end

    // R12 save bank readback; R2 and R3 wrote these entries
    viewIdx = 2'd0; #1; check64("R12 save0", saveView, 64'hFFFFFFFF00000000);
    viewIdx = 2'd1; #1; check64("R12 save1", saveView, 64'h00000000FFFFFFFF);
    viewIdx = 2'd2; #1; check64("R12 save2", saveView, 64'hF0F0F0F0F0F0F0F0);
    viewIdx = 2'd3; #1; check64("R12 save3", saveView, 64'h0);

    // R4 reopen, then R11: if command with cmdValid low has no effect
    idleVec = '{4'd3, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0, 64'h0, 1'b0};
    issue(1'b1, idleVec);
    check64("R4 reopen", execMask, 64'hFFFFFFFF00000000);
    idleVec = '{4'd1, 2'd3, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0, 64'h0, 1'b0};
    issue(1'b0, idleVec);
    check64("R11 idle mask", execMask, 64'hFFFFFFFF00000000);
    check64("R11 idle acc", accView, 64'hFFFFFFFF0F0F0FFF);
    viewIdx = 2'd3; #1;
    check64("R11 idle save", saveView, 64'h0);

    // R7 loop taken falls back low after a non-loop command
    idleVec = '{4'd7, 2'd0, 2'd0, 64'h0, 32'h0, 64'h0, 64'h0, 64'h0, 1'b0};
    issue(1'b1, idleVec);
    check64("R7 loop mask", execMask, 64'h00000000F0F0F000 & 64'h0);
    idleVec = '{4'd3, 2'd0, 2'd1, 64'h0, 32'h0, 64'h0, 64'h0, 64'h0, 1'b0};
    issue(1'b1, idleVec);
    check64("R7 taken low", {63'b0, loopTaken}, 64'h0);
    check64("R4 restore", execMask, 64'h00000000FFFFFFFF);
    check64("R10 nonzero", {63'b0, execZero}, 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule